// File: doc/BRIEF.md
# Receiver Clock-Recovery Lock-Mode Controller

This block chooses what a receiver's clock-and-data-recovery loop follows. The loop can follow the local reference clock or the incoming serial stream. After reset the loop follows the reference. In the automatic policy, the controller watches three digitally modelled status lines: signal presence, frequency within tolerance, and phase alignment. When all three have been good for a run of consecutive cycles, it hands the loop over to the data. While the loop follows the data, a status flag reports the frequency lock. If the frequency or the signal is lost, the loop goes back to the reference.

Two override pins can force either target, and they take priority over the automatic policy. Asserting the reference override forces reference tracking whatever the other pin says. Asserting only the data override forces data tracking. When both pins are low, the automatic policy runs.

The block also owns the enable of a divide-by-2 in the loop's feedback path. This enable is used only for dynamic rate changes when the link is configured for the PCIe 5 Gbps rate. It is set by a request to drop to the lower rate and cleared by a request to return to the higher rate.

Top module: `cdr_lock_ctrl`

## Requirements
- R1: While `rst_n` is low at a clock edge, the block returns to reference tracking with the qualification run cleared. After that edge, `lock_to_data`, `freq_locked` and `fb_div2_en` are all 0.
- R2: When `force_ref` is 1, `lock_to_data` is 0 in the same cycle, whatever `force_data` is.
- R3: When `force_ref` is 0 and `force_data` is 1, `lock_to_data` is 1 in the same cycle.
- R4: With both overrides at 0, the block moves from reference to data tracking at the clock edge that ends the QUAL_CYCLES-th consecutive cycle in which the lock condition holds. `lock_to_data` reads 1 from then on.
- R5: The lock condition is signal-ok AND `freq_ok` AND `phase_ok`. A cycle in which any one of them is 0 restarts the consecutive-cycle run from zero.
- R6: Signal-ok is `sig_det` when `pcie_mode` is 1. Signal-ok is constant 1 when `pcie_mode` is 0, so `sig_det` has no effect in that case.
- R7: `freq_locked` is 1 exactly when the automatic policy is tracking data and both overrides are 0.
- R8: While automatically tracking data, a cycle with `freq_ok` at 0 or signal-ok at 0 returns the block to reference tracking at the next edge, and `freq_locked` falls. A drop of `phase_ok` alone keeps data tracking.
- R9: Any cycle with an override asserted sends the automatic policy back to reference tracking with the run cleared. On release, a full new run of QUAL_CYCLES is needed.
- R10: With `pcie_mode` and `gen2_cfg` both 1, a cycle with `req_gen1` = 1 and `req_gen2` = 0 sets `fb_div2_en` at the next edge. A cycle with `req_gen2` = 1 and `req_gen1` = 0 clears it. Both requests together, or neither, leave it unchanged.
- R11: In any cycle where `pcie_mode` or `gen2_cfg` is 0, `fb_div2_en` is cleared at the next edge and rate requests are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference-domain clock |
| rst_n | input | 1 | Synchronous reset, active low |
| force_ref | input | 1 | Override: track the reference (highest priority) |
| force_data | input | 1 | Override: track the data |
| pcie_mode | input | 1 | 1 = PCIe protocol mode |
| gen2_cfg | input | 1 | 1 = link configured for the 5 Gbps rate |
| sig_det | input | 1 | Valid signal level seen at the receiver input |
| freq_ok | input | 1 | Recovered clock within the frequency tolerance |
| phase_ok | input | 1 | Recovered clock phase-matched to the reference |
| req_gen1 | input | 1 | Rate-change request to the lower rate |
| req_gen2 | input | 1 | Rate-change request to the higher rate |
| lock_to_data | output | 1 | 1 = loop follows data, 0 = follows the reference |
| freq_locked | output | 1 | Automatic hand-over to data is in effect |
| fb_div2_en | output | 1 | Feedback divide-by-2 enable |

## Verification
The hardest state to reach from the ports is a qualification run that is broken exactly one cycle before it would complete. The bench holds the three status lines good for QUAL_CYCLES-1 cycles and drops one of them for a single cycle. It then shows that the next run again needs the full count, not just the remainder. Releasing an override in the middle of a run, and returning from data tracking after only the phase line has dropped, are driven the same way: as directed sequences that a cycle-by-cycle reference model follows. A long stretch of biased random stimulus then covers the interleavings of these cases.

// File: rtl/cdr_lock_pkg.sv
// Shared types for the lock-mode controller.
// Assumes: nothing beyond IEEE 1800-2017.
package cdr_lock_pkg;
    typedef enum logic {
        TRACK_REF  = 1'b0,
        TRACK_DATA = 1'b1
    } track_e;
endpackage

// File: rtl/lock_qual_counter.sv
// Counts consecutive cycles in which the lock condition holds, and raises
// run_done in the cycle that completes QUAL_CYCLES of them.
// Assumes: QUAL_CYCLES >= 1; arm is low whenever no run should progress.
module lock_qual_counter #(
    parameter int QUAL_CYCLES = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic arm,
    input  logic cond,
    output logic run_done
);
    localparam int CW = $clog2(QUAL_CYCLES + 1);
    localparam logic [CW-1:0] LAST = CW'(QUAL_CYCLES - 1);

    logic [CW-1:0] run_cnt;

    // Completion of the run is seen in the cycle of its last good sample.
    always_comb begin
        run_done = arm && cond && (run_cnt == LAST);
    end

    // Counts good cycles; any gap, disarm or completion restarts the run.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            run_cnt <= '0;
        end else if (!arm || !cond || run_done) begin
            run_cnt <= '0;
        end else begin
            run_cnt <= run_cnt + 1'b1;
        end
    end

    // R5: a cycle without the condition leaves the run at zero.
    p_gap_restarts_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !cond |=> (run_cnt == '0));
    // R4: the run never passes its target length.
    p_cnt_bound_r4: assert property (@(posedge clk) disable iff (!rst_n)
        run_cnt < CW'(QUAL_CYCLES));
endmodule

// File: rtl/auto_lock_fsm.sv
// Automatic tracking policy. It starts on the reference, moves to data on
// run_done, and falls back when the frequency or the signal is lost.
// Assumes: auto_en is low while any manual override is asserted.
module auto_lock_fsm
    import cdr_lock_pkg::*;
(
    input  logic   clk,
    input  logic   rst_n,
    input  logic   auto_en,
    input  logic   run_done,
    input  logic   sig_ok,
    input  logic   freq_ok,
    input  logic   phase_ok,
    output track_e state
);
    track_e state_nx;

    // Next-state choice for the two-state tracking policy.
    always_comb begin
        state_nx = state;
        if (!auto_en) begin
            state_nx = TRACK_REF;
        end else if (state == TRACK_REF) begin
            if (run_done) state_nx = TRACK_DATA;
        end else if (!freq_ok || !sig_ok) begin
            state_nx = TRACK_REF;
        end
    end

    // State register with synchronous active-low reset.
    always_ff @(posedge clk) begin
        if (!rst_n) state <= TRACK_REF;
        else        state <= state_nx;
    end

    // R4: entry into data tracking only follows a cycle with all conditions good.
    p_entry_qualified_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (state == TRACK_DATA && $past(state) == TRACK_REF) |->
            $past(sig_ok && freq_ok && phase_ok));
    // R8: frequency loss while tracking data returns to the reference.
    p_drop_on_freq_loss_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (state == TRACK_DATA && !freq_ok) |=> (state == TRACK_REF));
    // R8: phase loss alone does not leave data tracking.
    p_phase_ignored_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (state == TRACK_DATA && auto_en && freq_ok && sig_ok && !phase_ok)
            |=> (state == TRACK_DATA));
    // R9: an override cycle always leaves the policy on the reference.
    p_override_resets_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !auto_en |=> (state == TRACK_REF));
endmodule

// File: rtl/rate_div_ctrl.sv
// Holds the feedback divide-by-2 enable for dynamic rate changes.
// Assumes: requests are level-qualified per cycle; opposing requests cancel.
module rate_div_ctrl (
    input  logic clk,
    input  logic rst_n,
    input  logic gen2_mode,
    input  logic req_low,
    input  logic req_high,
    output logic div_en
);
    // Set on a drop to the low rate, cleared on a return, forced off otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n || !gen2_mode) begin
            div_en <= 1'b0;
        end else if (req_low && !req_high) begin
            div_en <= 1'b1;
        end else if (req_high && !req_low) begin
            div_en <= 1'b0;
        end
    end

    // R11: leaving the 5 Gbps configuration clears the enable.
    p_div_low_outside_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !gen2_mode |=> !div_en);
    // R10: a lone low-rate request sets the enable.
    p_low_req_sets_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (gen2_mode && req_low && !req_high) |=> div_en);
    // R10: opposing requests together change nothing.
    p_both_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (gen2_mode && req_low && req_high) |=> $stable(div_en));
endmodule

// File: rtl/cdr_lock_ctrl.sv
// Top of the lock-mode controller. The override pins are resolved
// combinationally over the automatic policy. The qualification counter,
// the policy FSM and the rate divider control are instantiated here.
// Assumes: all inputs are synchronous to clk.
module cdr_lock_ctrl
    import cdr_lock_pkg::*;
#(
    parameter int QUAL_CYCLES = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic force_ref,
    input  logic force_data,
    input  logic pcie_mode,
    input  logic gen2_cfg,
    input  logic sig_det,
    input  logic freq_ok,
    input  logic phase_ok,
    input  logic req_gen1,
    input  logic req_gen2,
    output logic lock_to_data,
    output logic freq_locked,
    output logic fb_div2_en
);
    logic   auto_en;
    logic   sig_ok;
    logic   lock_cond;
    logic   run_done;
    logic   arm;
    track_e pol_state;

    // Resolve override priority and the mode-qualified signal condition.
    always_comb begin
        auto_en   = !force_ref && !force_data;
        sig_ok    = pcie_mode ? sig_det : 1'b1;
        lock_cond = sig_ok && freq_ok && phase_ok;
        arm       = auto_en && (pol_state == TRACK_REF);
    end

    lock_qual_counter #(
        .QUAL_CYCLES(QUAL_CYCLES)
    ) u_qual (
        .clk      (clk),
        .rst_n    (rst_n),
        .arm      (arm),
        .cond     (lock_cond),
        .run_done (run_done)
    );

    auto_lock_fsm u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .auto_en  (auto_en),
        .run_done (run_done),
        .sig_ok   (sig_ok),
        .freq_ok  (freq_ok),
        .phase_ok (phase_ok),
        .state    (pol_state)
    );

    rate_div_ctrl u_rate (
        .clk       (clk),
        .rst_n     (rst_n),
        .gen2_mode (pcie_mode && gen2_cfg),
        .req_low   (req_gen1),
        .req_high  (req_gen2),
        .div_en    (fb_div2_en)
    );

    // Drive the loop target and the lock status.
    always_comb begin
        if (force_ref)       lock_to_data = 1'b0;
        else if (force_data) lock_to_data = 1'b1;
        else                 lock_to_data = (pol_state == TRACK_DATA);
        freq_locked = auto_en && (pol_state == TRACK_DATA);
    end

    // R2: the reference override always wins at the output.
    p_ref_override_r2: assert property (@(posedge clk) disable iff (!rst_n)
        force_ref |-> !lock_to_data);
    // R7: the lock flag implies the loop is actually on data.
    p_flag_means_data_r7: assert property (@(posedge clk) disable iff (!rst_n)
        freq_locked |-> lock_to_data);
    // R6: outside PCIe, signal detect cannot block a qualified run.
    p_sigdet_ignored_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (!pcie_mode && arm && freq_ok && phase_ok) |=> !$past(run_done) || lock_to_data || !auto_en);
endmodule

// File: tb/cdr_lock_ctrl_test.sv
module cdr_lock_ctrl_test;
    localparam int Q = 6;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic force_ref = 0, force_data = 0, pcie_mode = 0, gen2_cfg = 0;
    logic sig_det = 0, freq_ok = 0, phase_ok = 0, req_gen1 = 0, req_gen2 = 0;
    logic lock_to_data, freq_locked, fb_div2_en;

    int checks = 0;
    int errors = 0;
    bit finished = 0;

    // Reference model state
    bit m_data = 0;
    int m_run = 0;
    bit m_div = 0;

    always #5 clk = ~clk;

    cdr_lock_ctrl #(.QUAL_CYCLES(Q)) uut (
        .clk(clk), .rst_n(rst_n), .force_ref(force_ref), .force_data(force_data),
        .pcie_mode(pcie_mode), .gen2_cfg(gen2_cfg), .sig_det(sig_det),
        .freq_ok(freq_ok), .phase_ok(phase_ok), .req_gen1(req_gen1),
        .req_gen2(req_gen2), .lock_to_data(lock_to_data),
        .freq_locked(freq_locked), .fb_div2_en(fb_div2_en)
    );

    task automatic check1(input string tag, input string what, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual=%b expected=%b at %0t", tag, what, act, exp, $time);
        end
    endtask

    // Compare outputs against the model, then advance both across one edge.
    task automatic tick(input string tag);
        bit e_ltd, e_fl, sd, cond;
        #2;
        e_ltd = force_ref ? 1'b0 : (force_data ? 1'b1 : m_data);
        e_fl  = !force_ref && !force_data && m_data;
        check1(tag, "lock_to_data", lock_to_data, e_ltd);
        check1(tag, "freq_locked", freq_locked, e_fl);
        check1(tag, "fb_div2_en", fb_div2_en, m_div);
        @(posedge clk);
        sd = pcie_mode ? sig_det : 1'b1;
        cond = sd && freq_ok && phase_ok;
        if (!rst_n) begin
            m_data = 0; m_run = 0; m_div = 0;
        end else begin
            if (force_ref || force_data) begin
                m_data = 0; m_run = 0;
            end else if (m_data) begin
                if (!freq_ok || !sd) begin m_data = 0; m_run = 0; end
            end else if (cond) begin
                m_run++;
                if (m_run >= Q) begin m_data = 1; m_run = 0; end
            end else begin
                m_run = 0;
            end
            if (!(pcie_mode && gen2_cfg)) m_div = 0;
            else if (req_gen1 && !req_gen2) m_div = 1;
            else if (req_gen2 && !req_gen1) m_div = 0;
        end
        @(negedge clk);
    endtask

    task automatic ticks(input string tag, input int n);
        for (int i = 0; i < n; i++) tick(tag);
    endtask

    task automatic set_st(input logic s, input logic f, input logic p);
        sig_det = s; freq_ok = f; phase_ok = p;
    endtask

    initial begin
        @(negedge clk);
        ticks("R1", 3);
        rst_n = 1;
        tick("R1");
        check1("R1", "post-reset target", lock_to_data, 1'b0);

        // Generic mode: sig_det low must not matter
        set_st(0, 1, 1);
        ticks("R6", Q - 1);
        check1("R4", "still on ref before run ends", lock_to_data, 1'b0);
        tick("R4");
        tick("R4");
        check1("R4", "on data after full run", lock_to_data, 1'b1);
        check1("R7", "flag set on data", freq_locked, 1'b1);

        // Phase drop alone keeps data; freq drop returns
        set_st(0, 1, 0);
        ticks("R8", 3);
        check1("R8", "phase loss ignored", lock_to_data, 1'b1);
        set_st(0, 0, 0);
        tick("R8");
        tick("R8");
        check1("R8", "freq loss returns", freq_locked, 1'b0);

        // Run broken one cycle short
        set_st(1, 1, 1);
        ticks("R5", Q - 1);
        set_st(1, 1, 0);
        tick("R5");
        set_st(1, 1, 1);
        ticks("R5", Q - 1);
        check1("R5", "run restarted after gap", lock_to_data, 1'b0);
        tick("R5");
        tick("R5");
        check1("R5", "full new run locks", lock_to_data, 1'b1);

        // PCIe: sig_det gates entry and exit
        set_st(0, 0, 0);
        tick("R8");
        pcie_mode = 1;
        set_st(0, 1, 1);
        ticks("R6", Q + 3);
        check1("R6", "no signal blocks lock", lock_to_data, 1'b0);
        set_st(1, 1, 1);
        ticks("R6", Q + 1);
        check1("R6", "signal allows lock", lock_to_data, 1'b1);
        set_st(0, 1, 1);
        tick("R8");
        tick("R8");
        check1("R8", "signal loss returns", lock_to_data, 1'b0);

        // Overrides
        force_ref = 1; force_data = 1;
        ticks("R2", 2);
        check1("R2", "ref wins over data", lock_to_data, 1'b0);
        force_ref = 0;
        ticks("R3", 2);
        check1("R3", "manual data", lock_to_data, 1'b1);
        check1("R7", "no flag in manual", freq_locked, 1'b0);
        force_data = 0;
        set_st(1, 1, 1);
        ticks("R9", Q - 2);
        force_ref = 1;
        tick("R9");
        force_ref = 0;
        ticks("R9", Q - 1);
        check1("R9", "run cleared by override", lock_to_data, 1'b0);
        ticks("R9", 3);
        check1("R9", "fresh run locks", lock_to_data, 1'b1);

        // Rate divider
        gen2_cfg = 1;
        req_gen1 = 1; tick("R10"); req_gen1 = 0; tick("R10");
        check1("R10", "gen1 request sets", fb_div2_en, 1'b1);
        req_gen1 = 1; req_gen2 = 1; tick("R10"); req_gen1 = 0; req_gen2 = 0; tick("R10");
        check1("R10", "both hold", fb_div2_en, 1'b1);
        req_gen2 = 1; tick("R10"); req_gen2 = 0; tick("R10");
        check1("R10", "gen2 request clears", fb_div2_en, 1'b0);
        req_gen1 = 1; tick("R10"); req_gen1 = 0;
        pcie_mode = 0; req_gen1 = 1; tick("R11"); tick("R11");
        check1("R11", "off outside gen2 config", fb_div2_en, 1'b0);
        req_gen1 = 0;

        // Biased random stretch
        for (int i = 0; i < 3000; i++) begin
            force_ref  = ($urandom_range(0, 29) == 0);
            force_data = ($urandom_range(0, 24) == 0);
            pcie_mode  = ($urandom_range(0, 199) == 0) ? ~pcie_mode : pcie_mode;
            gen2_cfg   = ($urandom_range(0, 99) == 0) ? ~gen2_cfg : gen2_cfg;
            sig_det    = ($urandom_range(0, 15) != 0);
            freq_ok    = ($urandom_range(0, 15) != 0);
            phase_ok   = ($urandom_range(0, 11) != 0);
            req_gen1   = ($urandom_range(0, 9) == 0);
            req_gen2   = ($urandom_range(0, 9) == 0);
            rst_n      = ($urandom_range(0, 499) != 0);
            tick("R4");
        end

        if (!finished) begin
            finished = 1;
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            checks++;
            errors++;
            $display("FAIL watchdog expired");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule